// File: doc/BRIEF.md
# Exception Entry Controller

This block updates the processor's exception state when the core takes an exception. The core drives a one-cycle entry strobe with an exception class, a cause code, the faulting program counter, a delay-slot flag and the current debug-mode flag. On that clock edge the block updates the exception program counter, the cause register, the status register and a pair of sticky debug flags. One cycle later it presents the handler address on the redirect output, together with a one-cycle valid pulse.

Three kinds of entry are handled: general exceptions, debug exceptions and the reset exception. An external interrupt is normally treated as a general exception. If it arrives while debug mode is active, it is rewritten into a debug interrupt instead. Interrupt prioritization and flushing the pipeline are the job of the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Register outputs change on the clock edge that samples `entry_valid` high. `redirect_valid` goes high for exactly one cycle, on the following edge, with `redirect_pc` valid in that cycle.
- R2: On a general entry with Status bit 1 (exception level) clear, EPC takes `fault_pc`, or `fault_pc - 4` when `in_delay_slot` is high. Cause bit 31 takes the value of `in_delay_slot`.
- R3: On a general entry with Status bit 1 already set, EPC and Cause bit 31 keep their values.
- R4: A general entry writes its code into Cause bits [6:2]. An external interrupt writes code 0 there. All other Cause bits keep their values.
- R5: A general entry sets Status bit 1, clears the mode field in Status bits [4:3], and leaves every other Status bit unchanged.
- R6: The redirect address of a general entry is 0x80000180.
- R7: An external interrupt taken with `debug_mode` high sets `dbg_flags` bit 1 and redirects to 0xBFC00480. It leaves EPC, Cause and Status unchanged.
- R8: A debug single-step entry sets `dbg_flags` bit 0 and redirects to 0xBFC00480. It leaves EPC, Cause and Status unchanged.
- R9: A reset entry redirects to 0xBFC00000 and clears Status bits [4:3]. It leaves EPC and Cause unchanged.
- R10: The class encoding is 0 = general, 1 = external interrupt, 2 = debug single-step, 3 = debug interrupt, 4 = reset. Classes 5 to 7, and cycles without a strobe, change no register and produce no redirect.
- R11: After reset, EPC is 0, Cause is 0, Status is 0x00000010 (user mode), `dbg_flags` is 0 and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_valid | input | 1 | One-cycle exception entry strobe |
| entry_class | input | 3 | Exception class (see R10) |
| entry_code | input | 5 | Cause code for a general exception |
| fault_pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| debug_mode | input | 1 | Core is currently in debug mode |
| epc_q | output | 32 | Exception program counter |
| cause_q | output | 32 | Cause register |
| status_q | output | 32 | Status register |
| dbg_flags | output | 2 | Sticky debug flags: bit 0 single-step, bit 1 debug interrupt |
| redirect_valid | output | 1 | Handler address valid, one-cycle pulse |
| redirect_pc | output | 32 | Handler address |

## Verification
Register results are due on the clock edge that samples the strobe. The redirect address and its valid pulse are due one edge after that. The bench drives the strobe on a falling edge and reads the registers at the next falling edge. It then drops the strobe and reads the redirect outputs one falling edge later, and once more after that to confirm the pulse has ended. Because the vector table runs in order, the exception-level bit carries over from row to row, so the rows where that bit is already set test EPC and delay-bit preservation against the values left by earlier rows.

// File: rtl/exc_entry_pkg.sv
// Shared class encoding, register field positions and decoded entry kind.
package exc_entry_pkg;

    typedef enum logic [2:0] {
        CLS_GENERAL  = 3'd0,
        CLS_EXT_INT  = 3'd1,
        CLS_DBG_STEP = 3'd2,
        CLS_DBG_INT  = 3'd3,
        CLS_RESET    = 3'd4
    } exc_class_e;

    typedef enum logic [1:0] {
        VSEL_GENERAL = 2'd0,
        VSEL_DEBUG   = 2'd1,
        VSEL_RESET   = 2'd2
    } vec_sel_e;

    typedef struct packed {
        logic       take_general;
        logic       take_debug;
        logic       take_reset;
        logic       dbg_step;
        logic       dbg_int;
        logic [4:0] code;
    } entry_kind_t;

    localparam int CAUSE_BD_BIT   = 31;
    localparam int CAUSE_CODE_LSB = 2;
    localparam int CODE_W         = 5;
    localparam int STATUS_EXL_BIT = 1;
    localparam int STATUS_KSU_LSB = 3;
    localparam int KSU_W          = 2;

endpackage

// File: rtl/exc_classify.sv
// Decodes the raw entry class into one entry kind.
// Assumes: class values 5..7 are meaningless and decode to no action.
// An external interrupt in debug mode becomes a debug interrupt.
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [2:0]  entry_class,
    input  logic [4:0]  entry_code,
    input  logic        debug_mode,
    output entry_kind_t kind
);

    // Map class and debug mode onto the action flags.
    always_comb begin
        kind = '0;
        case (entry_class)
            CLS_GENERAL: begin
                kind.take_general = 1'b1;
                kind.code         = entry_code;
            end
            CLS_EXT_INT: begin
                if (debug_mode) begin
                    kind.take_debug = 1'b1;
                    kind.dbg_int    = 1'b1;
                end else begin
                    kind.take_general = 1'b1;
                    kind.code         = '0;
                end
            end
            CLS_DBG_STEP: begin
                kind.take_debug = 1'b1;
                kind.dbg_step   = 1'b1;
            end
            CLS_DBG_INT: begin
                kind.take_debug = 1'b1;
                kind.dbg_int    = 1'b1;
            end
            CLS_RESET: kind.take_reset = 1'b1;
            default:   kind = '0;
        endcase
    end

endmodule

// File: rtl/exc_state_regs.sv
// Holds EPC, Cause, Status and the sticky debug flags.
// All of them update on the edge that samples the entry strobe.
// Assumes: the decoded kind is one-hot or empty.
module exc_state_regs
    import exc_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] STATUS_RST = 32'h0000_0010,
    parameter int          INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_valid,
    input  entry_kind_t     kind,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            in_delay_slot,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] status_q,
    output logic [1:0]      dbg_flags
);

    localparam logic [XLEN-1:0] INSN_STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] resume_pc;
    logic            at_exl;

    // Resume address backs up one instruction for a delay-slot fault.
    always_comb resume_pc = in_delay_slot ? (fault_pc - INSN_STEP) : fault_pc;
    always_comb at_exl = status_q[STATUS_EXL_BIT];

    // EPC and the Cause delay bit are captured only outside exception level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q <= '0;
            cause_q <= '0;
        end else if (entry_valid && kind.take_general) begin
            if (!at_exl) begin
                epc_q                 <= resume_pc;
                cause_q[CAUSE_BD_BIT] <= in_delay_slot;
            end
            cause_q[CAUSE_CODE_LSB +: CODE_W] <= kind.code;
        end
    end

    // Status: exception level and kernel mode on general entry, kernel mode on reset entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= XLEN'(STATUS_RST);
        end else if (entry_valid && (kind.take_general || kind.take_reset)) begin
            status_q[STATUS_KSU_LSB +: KSU_W] <= '0;
            if (kind.take_general) status_q[STATUS_EXL_BIT] <= 1'b1;
        end
    end

    // Sticky debug cause flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_flags <= '0;
        end else if (entry_valid && kind.take_debug) begin
            dbg_flags <= dbg_flags | {kind.dbg_int, kind.dbg_step};
        end
    end

    a_r2_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && kind.take_general && !at_exl) |=>
            (epc_q == ($past(in_delay_slot) ? $past(fault_pc) - INSN_STEP : $past(fault_pc)))
            && (cause_q[CAUSE_BD_BIT] == $past(in_delay_slot)));

    a_r3_epc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && kind.take_general && at_exl) |=>
            $stable(epc_q) && $stable(cause_q[CAUSE_BD_BIT]));

    a_r5_status_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && kind.take_general) |=>
            status_q[STATUS_EXL_BIT] && (status_q[STATUS_KSU_LSB +: KSU_W] == '0));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_valid || (kind == '0)) |=>
            $stable(epc_q) && $stable(cause_q) && $stable(status_q) && $stable(dbg_flags));

endmodule

// File: rtl/exc_vector_gen.sv
// Picks the handler address and presents it one cycle after the entry edge.
// Assumes: at most one entry per cycle; a new entry replaces a pending one.
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [31:0] DEBUG_VEC = 32'hBFC0_0480,
    parameter logic [31:0] GEN_BASE  = 32'h8000_0000,
    parameter logic [31:0] GEN_OFS   = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_valid,
    input  entry_kind_t     kind,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    localparam logic [XLEN-1:0] GEN_VEC = XLEN'(GEN_BASE + GEN_OFS);

    logic     take_any;
    logic     pend_valid;
    vec_sel_e pend_sel;
    vec_sel_e now_sel;
    logic [XLEN-1:0] vec_addr;

    // Any accepted entry produces a redirect.
    always_comb take_any = entry_valid && (kind.take_general || kind.take_debug || kind.take_reset);

    // Vector selector for the entry seen this cycle.
    always_comb begin
        if (kind.take_reset)      now_sel = VSEL_RESET;
        else if (kind.take_debug) now_sel = VSEL_DEBUG;
        else                      now_sel = VSEL_GENERAL;
    end

    // First stage: remember which vector the entry needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_sel   <= VSEL_GENERAL;
        end else begin
            pend_valid <= take_any;
            if (take_any) pend_sel <= now_sel;
        end
    end

    // Address lookup for the pending selector.
    always_comb begin
        case (pend_sel)
            VSEL_RESET: vec_addr = XLEN'(RESET_VEC);
            VSEL_DEBUG: vec_addr = XLEN'(DEBUG_VEC);
            default:    vec_addr = GEN_VEC;
        endcase
    end

    // Second stage: drive the redirect pulse and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= pend_valid;
            if (pend_valid) redirect_pc <= vec_addr;
        end
    end

    a_r1_redirect_due: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> ##1 redirect_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_any) |=> ##1 !redirect_valid);

endmodule

// File: rtl/exc_entry_ctrl.sv
// Top level: decodes the entry, updates exception state and emits the handler PC.
// Assumes: the core holds entry_valid for one cycle per exception taken.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] STATUS_RST = 32'h0000_0010,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] DEBUG_VEC  = 32'hBFC0_0480,
    parameter logic [31:0] GEN_BASE   = 32'h8000_0000,
    parameter logic [31:0] GEN_OFS    = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_valid,
    input  logic [2:0]      entry_class,
    input  logic [4:0]      entry_code,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            in_delay_slot,
    input  logic            debug_mode,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] status_q,
    output logic [1:0]      dbg_flags,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    entry_kind_t kind;

    exc_classify u_classify (
        .entry_class (entry_class),
        .entry_code  (entry_code),
        .debug_mode  (debug_mode),
        .kind        (kind)
    );

    exc_state_regs #(
        .XLEN       (XLEN),
        .STATUS_RST (STATUS_RST),
        .INSN_BYTES (4)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .entry_valid   (entry_valid),
        .kind          (kind),
        .fault_pc      (fault_pc),
        .in_delay_slot (in_delay_slot),
        .epc_q         (epc_q),
        .cause_q       (cause_q),
        .status_q      (status_q),
        .dbg_flags     (dbg_flags)
    );

    exc_vector_gen #(
        .XLEN      (XLEN),
        .RESET_VEC (RESET_VEC),
        .DEBUG_VEC (DEBUG_VEC),
        .GEN_BASE  (GEN_BASE),
        .GEN_OFS   (GEN_OFS)
    ) u_vec (
        .clk            (clk),
        .rst_n          (rst_n),
        .entry_valid    (entry_valid),
        .kind           (kind),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    a_r7_debug_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && (entry_class == 3'd1) && debug_mode) |=>
            dbg_flags[1] && $stable(status_q) && $stable(epc_q) && $stable(cause_q));

    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && (entry_class == 3'd2)) |=> dbg_flags[0] && $stable(status_q));

    a_r9_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && (entry_class == 3'd4)) |=> ##1 (redirect_pc == RESET_VEC));

endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

    typedef struct packed {
        logic [2:0]  cls;
        logic [4:0]  code;
        logic [31:0] pc;
        logic        ds;
        logic        dbg;
        logic [31:0] epc;
        logic [31:0] cause;
        logic [31:0] status;
        logic [1:0]  flags;
        logic        rv;
        logic [31:0] rpc;
    } vec_t;

    localparam int NV = 7;
    // Walked in order after reset; state carries from row to row.
    localparam vec_t TABLE [NV] = '{
        '{3'd2, 5'd0,  32'h0000_1000, 1'b0, 1'b0, 32'h0, 32'h0,         32'h10, 2'b01, 1'b1, 32'hBFC0_0480}, // R8
        '{3'd1, 5'd0,  32'h0000_2000, 1'b0, 1'b1, 32'h0, 32'h0,         32'h10, 2'b11, 1'b1, 32'hBFC0_0480}, // R7
        '{3'd0, 5'h0C, 32'h0000_0400, 1'b1, 1'b0, 32'h3FC, 32'h8000_0030, 32'h02, 2'b11, 1'b1, 32'h8000_0180}, // R2 R5 R6
        '{3'd0, 5'h04, 32'h0000_0800, 1'b0, 1'b0, 32'h3FC, 32'h8000_0010, 32'h02, 2'b11, 1'b1, 32'h8000_0180}, // R3 R4
        '{3'd1, 5'h1F, 32'h0000_0900, 1'b0, 1'b0, 32'h3FC, 32'h8000_0000, 32'h02, 2'b11, 1'b1, 32'h8000_0180}, // R4 ext code 0
        '{3'd7, 5'h1F, 32'h0000_0A00, 1'b1, 1'b0, 32'h3FC, 32'h8000_0000, 32'h02, 2'b11, 1'b0, 32'h0},         // R10
        '{3'd4, 5'd0,  32'h0000_0B00, 1'b0, 1'b0, 32'h3FC, 32'h8000_0000, 32'h02, 2'b11, 1'b1, 32'hBFC0_0000}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_valid = 1'b0;
    logic [2:0]  entry_class = '0;
    logic [4:0]  entry_code = '0;
    logic [31:0] fault_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        debug_mode = 1'b0;
    logic [31:0] epc_q, cause_q, status_q, redirect_pc;
    logic [1:0]  dbg_flags;
    logic        redirect_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_class(entry_class),
        .entry_code(entry_code), .fault_pc(fault_pc), .in_delay_slot(in_delay_slot),
        .debug_mode(debug_mode), .epc_q(epc_q), .cause_q(cause_q), .status_q(status_q),
        .dbg_flags(dbg_flags), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic string row_req(int i);
        case (i)
            0: return "R8";
            1: return "R7";
            2: return "R2/R5/R6";
            3: return "R3";
            4: return "R4";
            5: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Strobe one entry at a falling edge; return at the falling edge after the register edge.
    task automatic fire(logic [2:0] c, logic [4:0] code, logic [31:0] pc, logic ds, logic dbg);
        entry_valid = 1'b1; entry_class = c; entry_code = code;
        fault_pc = pc; in_delay_slot = ds; debug_mode = dbg;
        @(posedge clk); @(negedge clk);
        entry_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R11 reset state
        chk("R11", "epc", epc_q, 32'h0);
        chk("R11", "cause", cause_q, 32'h0);
        chk("R11", "status", status_q, 32'h10);
        chk("R11", "flags", {30'b0, dbg_flags}, 32'h0);
        chk("R11", "redirect_valid", {31'b0, redirect_valid}, 32'h0);

        // Table walk: registers one edge after strobe, redirect one edge later (R1)
        for (int i = 0; i < NV; i++) begin
            fire(TABLE[i].cls, TABLE[i].code, TABLE[i].pc, TABLE[i].ds, TABLE[i].dbg);
            chk(row_req(i), "epc", epc_q, TABLE[i].epc);
            chk(row_req(i), "cause", cause_q, TABLE[i].cause);
            chk(row_req(i), "status", status_q, TABLE[i].status);
            chk(row_req(i), "flags", {30'b0, dbg_flags}, {30'b0, TABLE[i].flags});
            chk("R1", "redirect_valid early", {31'b0, redirect_valid}, 32'h0);
            @(negedge clk);
            chk(row_req(i), "redirect_valid", {31'b0, redirect_valid}, {31'b0, TABLE[i].rv});
            if (TABLE[i].rv) chk(row_req(i), "redirect_pc", redirect_pc, TABLE[i].rpc);
            @(negedge clk);
            chk("R1", "redirect pulse ended", {31'b0, redirect_valid}, 32'h0);
        end

        // R2: fresh exception level, no delay slot; R5 keeps other Status bits
        do_reset();
        fire(3'd0, 5'h03, 32'h0000_1234, 1'b0, 1'b0);
        chk("R2", "epc no delay slot", epc_q, 32'h0000_1234);
        chk("R4", "cause code only", cause_q, 32'h0000_000C);
        chk("R5", "status", status_q, 32'h0000_0002);
        @(negedge clk);
        chk("R6", "general vector", redirect_pc, 32'h8000_0180);

        // R10: inputs toggle without strobe, nothing changes
        fault_pc = 32'hDEAD_BEE0; in_delay_slot = 1'b1; entry_class = 3'd0; entry_code = 5'h1F;
        repeat (3) @(negedge clk);
        chk("R10", "epc idle", epc_q, 32'h0000_1234);
        chk("R10", "cause idle", cause_q, 32'h0000_000C);
        chk("R10", "redirect idle", {31'b0, redirect_valid}, 32'h0);

        // R9: reset entry from user mode clears only the mode field
        do_reset();
        fire(3'd4, 5'd0, 32'h0000_0040, 1'b0, 1'b0);
        chk("R9", "status", status_q, 32'h0);
        chk("R9", "epc", epc_q, 32'h0);
        @(negedge clk);
        chk("R9", "reset vector", redirect_pc, 32'hBFC0_0000);

        // R3: back-to-back general entries, second keeps EPC and BD
        do_reset();
        entry_valid = 1'b1; entry_class = 3'd0; entry_code = 5'h02;
        fault_pc = 32'h0000_0100; in_delay_slot = 1'b1; debug_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        fault_pc = 32'h0000_0200; in_delay_slot = 1'b0; entry_code = 5'h05;
        @(posedge clk); @(negedge clk);
        entry_valid = 1'b0;
        chk("R3", "epc held", epc_q, 32'h0000_00FC);
        chk("R3", "cause BD held, code updated", cause_q, 32'h8000_0014);
        chk("R1", "redirect after first", {31'b0, redirect_valid}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule